// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of a serial memory write transaction into a one-page staging buffer, then commits them to a 256-byte storage array after a self-timed programming interval. A frame opens when the upstream command decoder has received a write opcode and its 8-bit start address. Each following complete data byte lands at the current in-page slot. The slot index then advances and wraps within the 16-byte page, so later bytes overwrite earlier ones once the index passes the top of the page.

When the host deselects, the decoder reports the total number of serial clocks seen in the transaction. A programming cycle starts only if that count is a whole number of bytes, at least one data byte was gathered, the write is permitted, and no write-protect abort arrived. During the cycle a busy flag stays high for a parameterised number of system clocks. Reads and new write frames are refused in that time, and the cycle carries on regardless. At the end only the slots that received bytes are written into the array. A one-cycle completion pulse, which the surrounding logic uses to clear its write enable latch, then marks the end of the cycle.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset `prog_busy` and `prog_done` are 0, `rd_vld` is 0, and every array byte reads back as 0xFF.
- R2: Data bytes are placed at the start address's low nibble and at consecutive slots after it. Only those slots change on commit, and the other bytes of the page keep their values. One data byte is a valid frame.
- R3: The slot index is the low 4 address bits and wraps from 15 to 0 inside the same page. A later byte for a slot replaces the earlier one.
- R4: A cycle starts only if `cs_bits` modulo 8 is 0 at `cs_rise` and at least one data byte was gathered. Otherwise no cycle starts and the array is unchanged.
- R5: `prog_busy` rises in the cycle after the `cs_rise` cycle that commits and stays high for exactly CYCLE_LEN cycles.
- R6: `prog_done` is high for exactly one cycle, the first cycle with `prog_busy` low after a cycle. The new bytes are readable from that cycle on.
- R7: If `wr_ok` is 0 in the `cs_rise` cycle, no cycle starts and the array is unchanged.
- R8: A `wp_abort` pulse at any point before `cs_rise` discards the frame. Bytes that follow it are ignored, and no cycle starts.
- R9: While `prog_busy` is high, `rd_req` yields no `rd_vld`, and `wr_start` and `byte_vld` are ignored. The running cycle still writes its original bytes.
- R10: When idle, `rd_req` with `rd_addr` gives `rd_vld`=1 and that byte on `rd_data` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start | input | 1 | Pulse: write opcode and address received, open a frame |
| wr_addr | input | 8 | Start address of the frame |
| byte_vld | input | 1 | Pulse: one complete data byte on byte_data |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse: chip-select deselect event |
| cs_bits | input | 12 | Serial clocks counted in the transaction at deselect |
| wr_ok | input | 1 | Write permitted (enable latch set, address not protected), sampled with cs_rise |
| wp_abort | input | 1 | Pulse: write-protect asserted, drop the pending frame |
| rd_req | input | 1 | Array read request |
| rd_addr | input | 8 | Array read address |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| prog_busy | output | 1 | Programming cycle in progress |
| prog_done | output | 1 | One-cycle pulse at the end of a cycle |

## Verification
The assertions assume that `byte_vld`, `wr_start` and `cs_rise` never share a cycle, that each is a single-cycle pulse, and that `cs_bits` stays below 4096. The stimulus drives each event alone on its own falling clock edge, one frame at a time. Frames are at most 20 bytes long, which also drives the wrap case. While a cycle runs, the bench deliberately injects a read request, a frame start and a data byte. These check that the refusal holds and that the cycle length is unchanged.

// File: rtl/pcb_pkg.sv
// Package: shared helpers for the page commit buffer.
// Assumes addresses split into a page index (upper bits) and an in-page slot.
package pcb_pkg;
    // Advance an in-page slot index, wrapping inside the page.
    function automatic logic [3:0] next_slot(input logic [3:0] cur);
        return cur + 4'd1;
    endfunction
endpackage

// File: rtl/pcb_collect.sv
// Module: pcb_collect
// Gathers the data bytes of one write frame into per-slot registers with a
// written-slot mask, and decides at deselect whether a cycle may start.
// Assumes wr_start, byte_vld and cs_rise are single-cycle pulses that never
// coincide, and that busy comes from the commit timer.
module pcb_collect
    import pcb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 4,
    parameter int BITCNT_W  = 12,
    localparam int SLOTS    = 1 << PAGE_BITS,
    localparam int PIDX_W   = ADDR_W - PAGE_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_start,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic                         byte_vld,
    input  logic [DATA_W-1:0]            byte_data,
    input  logic                         cs_rise,
    input  logic [BITCNT_W-1:0]          cs_bits,
    input  logic                         wr_ok,
    input  logic                         wp_abort,
    input  logic                         busy,
    output logic                         go,
    output logic [PIDX_W-1:0]            page_idx,
    output logic [SLOTS-1:0][DATA_W-1:0] slot_data,
    output logic [SLOTS-1:0]             slot_mask
);
    logic                 active;
    logic                 have_byte;
    logic [PAGE_BITS-1:0] slot;

    logic open_frame;
    logic take_byte;
    assign open_frame = wr_start && !busy && !wp_abort;
    assign take_byte  = byte_vld && active && !wp_abort;

    // Commit decision: deselect on a byte boundary with data, permitted, not aborted.
    assign go = cs_rise && active && have_byte && (cs_bits[2:0] == 3'd0)
                && wr_ok && !wp_abort;

    // Frame control: open, advance slot, close on deselect or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            have_byte <= 1'b0;
            slot      <= '0;
            page_idx  <= '0;
        end else if (wp_abort || cs_rise) begin
            active    <= 1'b0;
        end else if (open_frame) begin
            active    <= 1'b1;
            have_byte <= 1'b0;
            slot      <= wr_addr[PAGE_BITS-1:0];
            page_idx  <= wr_addr[ADDR_W-1:PAGE_BITS];
        end else if (take_byte) begin
            have_byte <= 1'b1;
            slot      <= next_slot(slot);
        end
    end

    // One register and mask bit per slot; a later byte replaces an earlier one.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_data[s] <= '0;
                slot_mask[s] <= 1'b0;
            end else if (wp_abort && !busy) begin
                slot_mask[s] <= 1'b0;
            end else if (open_frame && !cs_rise) begin
                slot_mask[s] <= 1'b0;
            end else if (take_byte && !cs_rise && slot == PAGE_BITS'(s)) begin
                slot_data[s] <= byte_data;
                slot_mask[s] <= 1'b1;
            end
        end
    end

    // R9: no frame may be open while a cycle runs.
    assert_idle_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !active);
    // R9: bytes during a cycle leave the staged mask untouched.
    assert_mask_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && byte_vld |=> $stable(slot_mask));
    // R8: an abort leaves no frame open.
    assert_abort_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wp_abort |=> !active);
endmodule

// File: rtl/pcb_timer.sv
// Module: pcb_timer
// Holds busy for CYCLE_LEN system clocks after a commit request and flags the
// final cycle. Assumes go only arrives while idle.
module pcb_timer #(
    parameter int CYCLE_LEN = 350000,
    localparam int CNT_W    = $clog2(CYCLE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic finish,
    output logic done
);
    logic [CNT_W-1:0] remain;

    assign finish = busy && (remain == '0);

    // Countdown of the self-timed interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (go && !busy) begin
                busy   <= 1'b1;
                remain <= CNT_W'(CYCLE_LEN - 1);
            end else if (finish) begin
                busy   <= 1'b0;
            end else if (busy) begin
                remain <= remain - 1'b1;
            end
        end
    end

    // R5: a commit request starts the cycle on the next edge.
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
    // R5: the cycle keeps running until its count is spent.
    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && remain != '0 |=> busy && remain == $past(remain) - 1'b1);
    // R6: completion follows the fall of busy.
    assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R6: completion lasts one cycle.
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pcb_array.sv
// Module: pcb_array
// Behavioural byte array, reset to all ones, written one page at a time under
// a slot mask, with a one-cycle read port that refuses requests while busy.
module pcb_array #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 4,
    localparam int DEPTH    = 1 << ADDR_W,
    localparam int SLOTS    = 1 << PAGE_BITS,
    localparam int PIDX_W   = ADDR_W - PAGE_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [PIDX_W-1:0]            page_idx,
    input  logic [SLOTS-1:0][DATA_W-1:0] slot_data,
    input  logic [SLOTS-1:0]             slot_mask,
    input  logic                         busy,
    input  logic                         rd_req,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic                         rd_vld,
    output logic [DATA_W-1:0]            rd_data
);
    logic [DEPTH-1:0][DATA_W-1:0] mem;

    // Each location takes its slot byte when its page commits and its slot was written.
    for (genvar a = 0; a < DEPTH; a++) begin : g_loc
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[a] <= '1;
            else if (commit && page_idx == PIDX_W'(a >> PAGE_BITS) && slot_mask[a % SLOTS])
                mem[a] <= slot_data[a % SLOTS];
        end
    end

    // Read port: serve only when no cycle is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd_req && !busy;
            if (rd_req && !busy)
                rd_data <= mem[rd_addr];
        end
    end

    // R9: no read is served out of a busy cycle.
    assert_no_read_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> !$past(busy));
    // R10: an idle request is always answered.
    assert_read_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !busy |=> rd_vld);
endmodule

// File: rtl/page_commit_buffer.sv
// Module: page_commit_buffer (top)
// Stages one page of write data, starts a timed programming cycle on a valid
// deselect, and commits the staged slots to the array at its end.
// Assumes the upstream decoder delivers whole bytes and one event per cycle.
module page_commit_buffer #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 4,
    parameter int BITCNT_W  = 12,
    parameter int CYCLE_LEN = 350000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_start,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                byte_vld,
    input  logic [DATA_W-1:0]   byte_data,
    input  logic                cs_rise,
    input  logic [BITCNT_W-1:0] cs_bits,
    input  logic                wr_ok,
    input  logic                wp_abort,
    input  logic                rd_req,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_vld,
    output logic [DATA_W-1:0]   rd_data,
    output logic                prog_busy,
    output logic                prog_done
);
    localparam int SLOTS  = 1 << PAGE_BITS;
    localparam int PIDX_W = ADDR_W - PAGE_BITS;

    logic                         go;
    logic                         finish;
    logic [PIDX_W-1:0]            page_idx;
    logic [SLOTS-1:0][DATA_W-1:0] slot_data;
    logic [SLOTS-1:0]             slot_mask;

    pcb_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
                  .BITCNT_W(BITCNT_W)) u_collect (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
        .cs_bits(cs_bits), .wr_ok(wr_ok), .wp_abort(wp_abort), .busy(prog_busy),
        .go(go), .page_idx(page_idx), .slot_data(slot_data), .slot_mask(slot_mask));

    pcb_timer #(.CYCLE_LEN(CYCLE_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(prog_busy),
        .finish(finish), .done(prog_done));

    pcb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(finish), .page_idx(page_idx),
        .slot_data(slot_data), .slot_mask(slot_mask), .busy(prog_busy),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data));
endmodule

// File: tb/test_page_commit_buffer.sv
// Bench: directed corner frames plus seeded random frames, checked against a
// byte-array model kept in the bench.
module test_page_commit_buffer;
    localparam int CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0, byte_vld = 1'b0, cs_rise = 1'b0;
    logic        wr_ok = 1'b0, wp_abort = 1'b0, rd_req = 1'b0;
    logic [7:0]  wr_addr = '0, byte_data = '0, rd_addr = '0;
    logic [11:0] cs_bits = '0;
    logic        rd_vld, prog_busy, prog_done;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    page_commit_buffer #(.CYCLE_LEN(CYC)) i_page_commit_buffer (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
        .cs_bits(cs_bits), .wr_ok(wr_ok), .wp_abort(wp_abort), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data),
        .prog_busy(prog_busy), .prog_done(prog_done));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R10: idle read returns the model byte one cycle later.
    task automatic read_chk(input logic [7:0] a, input string tag);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_vld == 1'b1, {tag, " R10 rd_vld"}, rd_vld, 1);
        chk(rd_data == model[a], tag, rd_data, model[a]);
    endtask

    function automatic bit commit_expected(input int n, input int extra,
                                           input bit ok, input bit aborted);
        return !aborted && n > 0 && extra == 0 && ok;
    endfunction

    task automatic run_frame(input logic [7:0] addr, input int n, input int extra,
                             input bit ok, input int abort_at, input string tag);
        logic [7:0] sb [16];
        bit [15:0]  sm = '0;
        int         off = addr[3:0];
        bit         aborted = 1'b0;
        bit         exp_go;
        int         cnt = 0;
        wr_start = 1'b1; wr_addr = addr;
        @(negedge clk);
        wr_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i == abort_at) begin
                wp_abort = 1'b1; @(negedge clk); wp_abort = 1'b0; aborted = 1'b1;
            end
            byte_data = 8'($urandom); byte_vld = 1'b1;
            if (!aborted) begin sb[off] = byte_data; sm[off] = 1'b1; end
            off = (off + 1) % 16;
            @(negedge clk);
            byte_vld = 1'b0;
        end
        if (abort_at == n && !aborted) begin
            wp_abort = 1'b1; @(negedge clk); wp_abort = 1'b0; aborted = 1'b1;
        end
        exp_go = commit_expected(n, extra, ok, aborted);
        cs_rise = 1'b1; cs_bits = 12'(16 + 8 * n + extra); wr_ok = ok;
        @(negedge clk);
        cs_rise = 1'b0; wr_ok = 1'b0;
        if (exp_go) begin
            chk(prog_busy == 1'b1, {tag, " R5 busy rise"}, prog_busy, 1);
            while (prog_busy && cnt < 1000) begin
                cnt++;
                if (cnt == 3) begin rd_req = 1'b1; rd_addr = addr; end
                if (cnt == 4) begin
                    chk(rd_vld == 1'b0, {tag, " R9 read refused"}, rd_vld, 0);
                    rd_req = 1'b0;
                    wr_start = 1'b1; wr_addr = addr ^ 8'h01;
                end
                if (cnt == 5) begin wr_start = 1'b0; byte_vld = 1'b1; byte_data = 8'hA5; end
                if (cnt == 6) byte_vld = 1'b0;
                @(negedge clk);
            end
            chk(cnt == CYC, {tag, " R5 busy length"}, cnt, CYC);
            chk(prog_done == 1'b1, {tag, " R6 done"}, prog_done, 1);
            for (int j = 0; j < 16; j++)
                if (sm[j]) model[{addr[7:4], 4'(j)}] = sb[j];
            read_chk({addr[7:4], 4'h0}, {tag, " R6 data visible"});
            chk(prog_done == 1'b0, {tag, " R6 done single"}, prog_done, 0);
        end else begin
            chk(prog_busy == 1'b0, {tag, " R4 R7 R8 no cycle"}, prog_busy, 0);
            @(negedge clk);
            chk(prog_busy == 1'b0, {tag, " R4 R7 R8 no cycle later"}, prog_busy, 0);
        end
        for (int j = 0; j < 16; j++)
            read_chk({addr[7:4], 4'(j)}, {tag, " R2 R3 page"});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int a = 0; a < 256; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prog_busy == 1'b0, "R1 busy reset", prog_busy, 0);
        chk(prog_done == 1'b0, "R1 done reset", prog_done, 0);
        chk(rd_vld == 1'b0, "R1 rd_vld reset", rd_vld, 0);
        read_chk(8'h00, "R1 init ff");
        read_chk(8'hFF, "R1 init ff");
        run_frame(8'h35, 1, 0, 1'b1, -1, "R2 single byte");
        run_frame(8'h4C, 20, 0, 1'b1, -1, "R3 wrap");
        run_frame(8'h60, 3, 3, 1'b1, -1, "R4 misaligned");
        run_frame(8'h70, 0, 0, 1'b1, -1, "R4 zero bytes");
        run_frame(8'h80, 4, 0, 1'b0, -1, "R7 not permitted");
        run_frame(8'h90, 5, 0, 1'b1, 2, "R8 abort mid");
        run_frame(8'h93, 2, 0, 1'b1, 2, "R8 abort late");
        run_frame(8'h37, 16, 0, 1'b1, -1, "R3 full page");
        for (int k = 0; k < 25; k++) begin
            int n = int'($urandom % 21);
            int extra = ($urandom % 4 == 0) ? int'(1 + $urandom % 7) : 0;
            bit ok = ($urandom % 6 != 0);
            int ab = ($urandom % 8 == 0) ? int'($urandom % (n + 1)) : -1;
            run_frame(8'($urandom), n, extra, ok, ab, "R2 random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule